// File: doc/BRIEF.md
# Maskable Interrupt Combiner

This block collects up to 32 interrupt sources into one request line for a processor core. Each source has a sticky status bit. A source that is high for a single cycle sets its bit, and the bit then stays set until software clears it. A mask register chooses which status bits may raise the request. The request output is high whenever a status bit and its matching mask bit are both set. The output is registered, so it follows the status and mask registers one clock later.

Software reaches both registers through a small special-purpose register port. The port has an address, a write enable, write data and combinational read data. An address is built as a group number shifted left by 11 plus a register index. Both registers sit in group 9. Writing the mask register replaces it completely. Writing the status register does not store the data. Instead, each 1 in the data clears the matching status bit, so a handler can acknowledge only the sources it has served.

Top module: `mask_irq_ctrl`

## Requirements
- R1: While reset is asserted and straight after it is released, the mask register, the status register and the request output are all zero.
- R2: The mask register answers at address (9<<11)+0 = 0x4800. The status register answers at address (9<<11)+2 = 0x4802.
- R3: A write to 0x4802 clears every status bit whose write-data bit is 1. Status bits written as 0 keep their value.
- R4: A source input that is high at a clock edge sets its status bit at that edge. When a source is high in the same cycle that a status write clears its bit, the bit ends up set.
- R5: A write to 0x4800 replaces all 32 mask bits with the write data at that clock edge.
- R6: After each clock edge, the request output equals the OR over all bits of (status AND mask) as those registers stood before that edge. The request therefore rises or falls one clock after a status or mask change, including a change made by a mask write.
- R7: The read data shows the current contents of the register at the presented address, in the same cycle, and a read changes no state.
- R8: A read of any other address returns zero. A write to any other address, or a cycle with write enable low, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 16 | Register address, group<<11 plus index |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data; clear pattern when the status register is addressed |
| regRdData | output | 32 | Combinational read data for regAddr |
| srcIrq | input | 32 | Interrupt source inputs, one per status bit |
| irqReq | output | 1 | Registered combined interrupt request |

## Verification
The bench drives a source in the same cycle as a status write that clears that source's bit. A design that let the clear win would drop an interrupt that arrived during acknowledge. It also writes a status pattern that mixes ones and zeros, so a design that loaded the data, or cleared the whole register, would leave the wrong bits set. It follows the request output cycle by cycle after mask writes and status clears. A request computed without the register stage, or one that ignored a newly written mask, would show up there one cycle early or not at all. The bench also sends writes to unmapped addresses and writes with the enable low. A loose address decode would change a register on those cycles, or return nonzero read data on an unmapped read.

// File: rtl/mask_irq_pkg.sv
package mask_irq_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MASK = 2'd1,
    RD_STAT = 2'd2
  } rdSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   maskWr;
    logic   statClr;
    rdSel_e rdSel;
  } regStrobe_t;

  // Address of a register: group in the upper field, index below bit 11
  function automatic int unsigned regAddrOf(input int unsigned grp, input int unsigned idx);
    return (grp << 11) + idx;
  endfunction

endpackage

// File: rtl/mask_irq_decode.sv
module mask_irq_decode
  import mask_irq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int GROUP    = 9,
  parameter int MASK_IDX = 0,
  parameter int STAT_IDX = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(regAddrOf(GROUP, MASK_IDX));
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(regAddrOf(GROUP, STAT_IDX));

  logic hitMask;
  logic hitStat;

  assign hitMask = (regAddr == MASK_ADDR);
  assign hitStat = (regAddr == STAT_ADDR);

  always_comb begin
    strobe.maskWr  = regWrEn && hitMask;
    strobe.statClr = regWrEn && hitStat;
    if (hitMask)      strobe.rdSel = RD_MASK;
    else if (hitStat) strobe.rdSel = RD_STAT;
    else              strobe.rdSel = RD_NONE;
  end

  // R8: a write strobe is raised only for a mapped address with the enable high
  always_comb begin
    assert_strobe_mapped_R8: assert (!(strobe.maskWr || strobe.statClr) || (regWrEn && (strobe.rdSel != RD_NONE)));
  end

endmodule

// File: rtl/mask_irq_datapath.sv
module mask_irq_datapath
  import mask_irq_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  regStrobe_t       strobe,
  input  logic [N_SRC-1:0] wrData,
  input  logic [N_SRC-1:0] srcIn,
  output logic [N_SRC-1:0] rdData,
  output logic             irqOut
);

  logic [N_SRC-1:0] maskQ;
  logic [N_SRC-1:0] statQ;
  logic [N_SRC-1:0] clrVec;
  logic             irqQ;

  assign clrVec = strobe.statClr ? wrData : '0;

  // One sticky flop per source; a set wins over a same-cycle clear
  for (genvar b = 0; b < N_SRC; b++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         statQ[b] <= 1'b0;
      else if (srcIn[b])  statQ[b] <= 1'b1;
      else if (clrVec[b]) statQ[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqQ <= 1'b0;
    else        irqQ <= |(statQ & maskQ);
  end

  assign irqOut = irqQ;

  always_comb begin
    case (strobe.rdSel)
      RD_MASK: rdData = maskQ;
      RD_STAT: rdData = statQ;
      default: rdData = '0;
    endcase
  end

  // R3: every bit cleared by a write is zero afterwards unless its source was high
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.statClr |=> ((statQ & $past(wrData) & ~$past(srcIn)) == '0));

  // R4: every source seen high is set afterwards
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|srcIn) |=> ((statQ & $past(srcIn)) == $past(srcIn)));

  // R8: with no clear and no source, the status holds
  assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.statClr && (srcIn == '0)) |=> $stable(statQ));

  // R5: a mask write loads all bits
  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.maskWr |=> (maskQ == $past(wrData)));

  // R6: the request follows the masked status one cycle later
  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == $past(|(statQ & maskQ))));

endmodule

// File: rtl/mask_irq_ctrl.sv
module mask_irq_ctrl
  import mask_irq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int N_SRC    = 32,
  parameter int GROUP    = 9,
  parameter int MASK_IDX = 0,
  parameter int STAT_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [N_SRC-1:0]  regWrData,
  output logic [N_SRC-1:0]  regRdData,
  input  logic [N_SRC-1:0]  srcIrq,
  output logic              irqReq
);

  regStrobe_t strobe;

  mask_irq_decode #(
    .ADDR_W  (ADDR_W),
    .GROUP   (GROUP),
    .MASK_IDX(MASK_IDX),
    .STAT_IDX(STAT_IDX)
  ) u_decode (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  mask_irq_datapath #(
    .N_SRC(N_SRC)
  ) u_datapath (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .wrData(regWrData),
    .srcIn (srcIrq),
    .rdData(regRdData),
    .irqOut(irqReq)
  );

endmodule

// File: tb/mask_irq_ctrl_bench.sv
module mask_irq_ctrl_bench;

  localparam logic [15:0] A_MASK = 16'h4800;
  localparam logic [15:0] A_STAT = 16'h4802;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] srcIrq = '0;
  logic        irqReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // scoreboard: bit 32 set means an irq check, else a read-data check
  logic [32:0] expQ[$];
  string       tagQ[$];

  // bench model
  logic [31:0] mdlMask = '0;
  logic [31:0] mdlStat = '0;
  logic        mdlIrq  = 1'b0;

  always #5 clk = ~clk;

  mask_irq_ctrl u_mask_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .srcIrq(srcIrq), .irqReq(irqReq)
  );

  // monitor: compare what the driver queued for this cycle
  always @(negedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      logic [32:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (e[32]) begin
        if (irqReq !== e[0]) begin
          failures++;
          $display("FAIL %s irqReq actual %b expected %b", t, irqReq, e[0]);
        end
      end else if (regRdData !== e[31:0]) begin
        failures++;
        $display("FAIL %s regRdData@%h actual %h expected %h", t, regAddr, regRdData, e[31:0]);
      end
    end
  end

  function automatic logic [31:0] mdlRead(input logic [15:0] a);
    if (a == A_MASK) return mdlMask;
    if (a == A_STAT) return mdlStat;
    return '0;
  endfunction

  // driver: one cycle of stimulus, expectations pushed, model advanced
  task automatic step(input string tag, input logic [15:0] a, input logic we,
                      input logic [31:0] d, input logic [31:0] src);
    logic [31:0] clr;
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = d; srcIrq = src;
    expQ.push_back({1'b0, mdlRead(a)}); tagQ.push_back(tag);
    expQ.push_back({1'b1, 31'd0, mdlIrq}); tagQ.push_back(tag);
    clr = (we && a == A_STAT) ? d : '0;
    mdlIrq  = |(mdlStat & mdlMask);
    mdlStat = (mdlStat & ~clr) | src;
    if (we && a == A_MASK) mdlMask = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values under reset
    expQ.push_back({1'b1, 32'd0}); tagQ.push_back("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", A_MASK, 0, '0, '0);
    step("R1", A_STAT, 0, '0, '0);
    // R2 R5: mask write and readback
    step("R5", A_MASK, 1, 32'h0000_00FF, '0);
    step("R2", A_MASK, 0, '0, '0);
    // R4: one-cycle pulse on bit 3 latches; R6: request one clock later
    step("R4", A_STAT, 0, '0, 32'h0000_0008);
    step("R6", A_STAT, 0, '0, '0);
    step("R6", A_STAT, 0, '0, '0);
    // R3: clear with zeros keeps, then clear bit 3
    step("R3", A_STAT, 1, '0, '0);
    step("R3", A_STAT, 1, 32'h0000_0008, '0);
    step("R6", A_STAT, 0, '0, '0);
    step("R6", A_STAT, 0, '0, '0);
    // R4: set and clear of bit 5 in one cycle keeps it set
    step("R4", A_STAT, 0, '0, 32'h0000_0120);
    step("R4", A_STAT, 1, 32'h0000_0020, 32'h0000_0020);
    step("R3", A_STAT, 1, 32'h0000_0100, '0);
    step("R4", A_STAT, 0, '0, '0);
    // R5 R6: mask cleared, request drops one clock later; full replace
    step("R5", A_MASK, 1, '0, '0);
    step("R6", A_MASK, 0, '0, '0);
    step("R6", A_MASK, 0, '0, '0);
    step("R5", A_MASK, 1, 32'hFFFF_0000, 32'h8000_0000);
    step("R5", A_MASK, 0, '0, '0);
    step("R6", A_STAT, 0, '0, '0);
    step("R6", A_STAT, 0, '0, '0);
    // R8: unmapped reads and writes, disabled writes
    step("R8", 16'h4801, 1, 32'hFFFF_FFFF, '0);
    step("R8", 16'h4000, 1, 32'hFFFF_FFFF, '0);
    step("R8", 16'h0802, 1, 32'hFFFF_FFFF, '0);
    step("R8", A_STAT, 0, 32'hFFFF_FFFF, '0);
    step("R8", A_MASK, 0, 32'h0, '0);
    step("R8", A_STAT, 0, '0, '0);
    // R7: random traffic, reads must mirror the model
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      logic [1:0]  pick;
      pick = 2'($urandom_range(0, 3));
      a = (pick == 0) ? A_MASK : (pick == 1) ? A_STAT : (pick == 2) ? 16'h4803 : A_STAT;
      step("R7", a, 1'($urandom_range(0, 1)), $urandom & $urandom,
           ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0);
    end
    step("R7", A_STAT, 0, '0, '0);
    @(negedge clk);
    #5;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule